// File: doc/BRIEF.md
# Full-Bridge Lamp Clock with Strike Sweep

This block produces the two drive phases for a full-bridge lamp inverter. A phase accumulator, clocked from a fixed system clock, turns a frequency tuning word into a square wave. A dead-time stage then splits that wave into two phases that never overlap. The programmed operating frequency is meant to sit between 20 kHz and 100 kHz, and 60 kHz is the usual choice.

An unlit lamp leaves the resonant tank unloaded, so the block raises its frequency during startup. While no strike has been reported, an offset is added to the tuning word. The offset grows by a fixed step at regular intervals and is capped at 40 % of the tuning word, which puts the output at no more than 140 % of the programmed frequency. Once the strike flag is raised, the offset shrinks by the same step at the same rate until it reaches zero, so the frequency glides back to the preset value instead of stepping to it. If the strike flag drops again, for example because the lamp has opened, the sweep resumes. A strap input holds the block at exactly the programmed frequency at all times.

Top module: `lamp_clk_sweep`

## Requirements
- R1: While `enable` is low, both phases are low and `sweeping` is low one clock later, and the offset is cleared, so re-enabling starts at the programmed frequency.
- R2: With zero offset, `drv_a` has rising edges at an average rate of `tune_word / 2^ACC_W` per clock. Over a window of N clocks the count is `N*tune_word/2^ACC_W`, within plus or minus 1.
- R3: `drv_a` and `drv_b` are never high in the same cycle.
- R4: At every transition of the internal square wave, both phases stay low for exactly `dead_cnt + 1` clocks before the newly active phase rises.
- R5: While enabled, unstrapped and with `strike_seen` low, the offset rises by `SWEEP_STEP` once every `SWEEP_INTERVAL` clocks. After enable, `sweeping` goes high after the first interval and not earlier.
- R6: The offset never exceeds `floor(2*tune_word/5)`. With a long unstruck sweep, the output settles at the programmed word plus that ceiling.
- R7: After `strike_seen` rises, the offset falls by `SWEEP_STEP` per interval down to zero. `sweeping` stays high during the glide, and the output then returns to the R2 rate.
- R8: While `sweep_off` is high, the offset is zero one clock later, `sweeping` stays low and the output runs at exactly the programmed rate.
- R9: If `strike_seen` falls again while enabled and unstrapped, the offset starts rising again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the oscillator; low forces both phases low |
| tune_word | input | ACC_W | Programmed frequency tuning word |
| strike_seen | input | 1 | High once the lamp has struck |
| sweep_off | input | 1 | Strap: disables the startup sweep |
| dead_cnt | input | DT_W | Dead time; the interval is this value plus one clock |
| drv_a | output | 1 | Bridge phase A |
| drv_b | output | 1 | Bridge phase B, complementary to A |
| sweeping | output | 1 | High while the offset is non-zero |

## Verification
The internal square wave updates one clock after the accumulator, and the phases update one clock after that. For this reason the bench never compares phase edges against absolute cycle numbers: frequency is checked as an edge count over a long window with a tolerance of one edge, and dead time as the number of sampled cycles in which both phases are low. `sweeping` follows its offset register with no extra delay. The sweep onset is therefore checked two clocks before and one clock after the first interval ends. Glide and clearing are checked at points far enough from the computed end of the ramp that their outcome is unambiguous. All sampling is done on the falling clock edge.

// File: rtl/lcs_pkg.sv
package lcs_pkg;

    // direction of the sweep offset in a given cycle
    typedef enum logic [1:0] {
        SW_CLEAR = 2'd0,
        SW_RISE  = 2'd1,
        SW_FALL  = 2'd2
    } sweep_dir_e;

    // condition of the bridge output stage
    typedef enum logic [1:0] {
        BR_OFF   = 2'd0,
        BR_DEAD  = 2'd1,
        BR_DRIVE = 2'd2
    } bridge_st_e;

    // ceiling ratio of the sweep offset: CEIL_NUM / CEIL_DEN of the base word
    localparam int unsigned CEIL_NUM = 2;
    localparam int unsigned CEIL_DEN = 5;

endpackage

// File: rtl/lcs_sweep_ctrl.sv
module lcs_sweep_ctrl
    import lcs_pkg::*;
#(
    parameter int ACC_W          = 32,
    parameter int SWEEP_STEP     = 4096,
    parameter int SWEEP_INTERVAL = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             sweep_off,
    input  logic             strike_seen,
    input  logic [ACC_W-1:0] tune_word,
    output logic [ACC_W-1:0] word_out,
    output logic             sweeping
);
    localparam int EW = ACC_W + 2;
    localparam int CW = (SWEEP_INTERVAL > 1) ? $clog2(SWEEP_INTERVAL) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(SWEEP_INTERVAL - 1);
    localparam logic [EW-1:0] STEP_X   = EW'(SWEEP_STEP);

    typedef struct packed {
        logic [ACC_W-1:0] ofs;
        logic [CW-1:0]    cnt;
    } sweep_st_t;

    sweep_st_t  st_d, st_q;
    sweep_dir_e dir;
    logic [EW-1:0] ceil_x;
    logic [EW-1:0] ofs_x;
    logic [EW-1:0] rise_x;
    logic          tick;

    always_comb begin
        ceil_x = (EW'(tune_word) * EW'(CEIL_NUM)) / EW'(CEIL_DEN);
        ofs_x  = EW'(st_q.ofs);
        rise_x = ofs_x + STEP_X;
        tick   = (st_q.cnt == CNT_LAST);
        st_d   = st_q;
        if (!enable || sweep_off) begin
            dir  = SW_CLEAR;
        end else if (strike_seen) begin
            dir  = SW_FALL;
        end else begin
            dir  = SW_RISE;
        end

        case (dir)
            SW_CLEAR: begin
                st_d.ofs = '0;
                st_d.cnt = '0;
            end
            SW_RISE: begin
                st_d.cnt = tick ? '0 : st_q.cnt + 1'b1;
                if (ofs_x > ceil_x) begin
                    st_d.ofs = ceil_x[ACC_W-1:0];
                end else if (tick) begin
                    if (rise_x > ceil_x) begin
                        st_d.ofs = ceil_x[ACC_W-1:0];
                    end else begin
                        st_d.ofs = rise_x[ACC_W-1:0];
                    end
                end
            end
            SW_FALL: begin
                st_d.cnt = tick ? '0 : st_q.cnt + 1'b1;
                if (ofs_x > ceil_x) begin
                    st_d.ofs = ceil_x[ACC_W-1:0];
                end else if (tick) begin
                    if (ofs_x > STEP_X) begin
                        st_d.ofs = st_q.ofs - STEP_X[ACC_W-1:0];
                    end else begin
                        st_d.ofs = '0;
                    end
                end
            end
            default: begin
                st_d.ofs = '0;
                st_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_out = tune_word + st_q.ofs;
    assign sweeping = (st_q.ofs != '0);

endmodule

// File: rtl/lcs_phase_acc.sv
module lcs_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [ACC_W-1:0] word_in,
    output logic             square
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             sq;
    } acc_st_t;

    acc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (enable) begin
            st_d.acc = st_q.acc + word_in;
        end else begin
            st_d.acc = '0;
        end
        st_d.sq = st_q.acc[ACC_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign square = st_q.sq;

endmodule

// File: rtl/lcs_deadtime.sv
module lcs_deadtime
    import lcs_pkg::*;
#(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            square,
    input  logic [DT_W-1:0] dead_cnt,
    output logic            out_a,
    output logic            out_b
);
    typedef struct packed {
        bridge_st_e      st;
        logic            prev;
        logic [DT_W-1:0] cnt;
        logic            a;
        logic            b;
    } dt_st_t;

    dt_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = square;
        if (!enable) begin
            st_d.st  = BR_OFF;
            st_d.cnt = dead_cnt;
            st_d.a   = 1'b0;
            st_d.b   = 1'b0;
        end else if (square != st_q.prev) begin
            st_d.st  = BR_DEAD;
            st_d.cnt = dead_cnt;
            st_d.a   = 1'b0;
            st_d.b   = 1'b0;
        end else if (st_q.cnt != '0) begin
            st_d.st  = BR_DEAD;
            st_d.cnt = st_q.cnt - 1'b1;
            st_d.a   = 1'b0;
            st_d.b   = 1'b0;
        end else begin
            st_d.st  = BR_DRIVE;
            st_d.a   = square;
            st_d.b   = ~square;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{st: BR_OFF, prev: 1'b0, cnt: '0, a: 1'b0, b: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_a = st_q.a;
    assign out_b = st_q.b;

endmodule

// File: rtl/lamp_clk_sweep.sv
module lamp_clk_sweep #(
    parameter int ACC_W          = 32,
    parameter int SWEEP_STEP     = 4096,
    parameter int SWEEP_INTERVAL = 256,
    parameter int DT_W           = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [ACC_W-1:0] tune_word,
    input  logic             strike_seen,
    input  logic             sweep_off,
    input  logic [DT_W-1:0]  dead_cnt,
    output logic             drv_a,
    output logic             drv_b,
    output logic             sweeping
);
    logic [ACC_W-1:0] word_w;
    logic             square_w;

    lcs_sweep_ctrl #(
        .ACC_W          (ACC_W),
        .SWEEP_STEP     (SWEEP_STEP),
        .SWEEP_INTERVAL (SWEEP_INTERVAL)
    ) u_sweep (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .sweep_off   (sweep_off),
        .strike_seen (strike_seen),
        .tune_word   (tune_word),
        .word_out    (word_w),
        .sweeping    (sweeping)
    );

    lcs_phase_acc #(
        .ACC_W (ACC_W)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .word_in (word_w),
        .square  (square_w)
    );

    lcs_deadtime #(
        .DT_W (DT_W)
    ) u_dead (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .square   (square_w),
        .dead_cnt (dead_cnt),
        .out_a    (drv_a),
        .out_b    (drv_b)
    );

endmodule

// File: rtl/lamp_clk_sweep_chk.sv
module lamp_clk_sweep_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic strike_seen,
    input logic sweep_off,
    input logic drv_a,
    input logic drv_b,
    input logic sweeping
);
    // R3
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(drv_a && drv_b));

    // R1
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!drv_a && !drv_b && !sweeping));

    // R8
    strap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && sweep_off) |=> !sweeping);

    // R4
    dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_b) |-> !$past(drv_a));

    // R5
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sweeping) |-> ($past(enable) && !$past(sweep_off) && !$past(strike_seen)));

    // R7
    fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sweeping) |-> ($past(strike_seen) || !$past(enable) || $past(sweep_off)));
endmodule

bind lamp_clk_sweep lamp_clk_sweep_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .strike_seen (strike_seen),
    .sweep_off   (sweep_off),
    .drv_a       (drv_a),
    .drv_b       (drv_b),
    .sweeping    (sweeping)
);

// File: tb/test_lamp_clk_sweep.sv
module test_lamp_clk_sweep;
    localparam int ACC_W = 16;
    localparam int STEP  = 64;
    localparam int IVL   = 8;
    localparam int DT_W  = 4;
    localparam int WIN   = 8192;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic [ACC_W-1:0] tune_word = '0;
    logic             strike_seen = 1'b0;
    logic             sweep_off = 1'b1;
    logic [DT_W-1:0]  dead_cnt = '0;
    logic             drv_a, drv_b, sweeping;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int overlap = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lamp_clk_sweep #(
        .ACC_W(ACC_W), .SWEEP_STEP(STEP), .SWEEP_INTERVAL(IVL), .DT_W(DT_W)
    ) i_lamp_clk_sweep (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tune_word(tune_word),
        .strike_seen(strike_seen), .sweep_off(sweep_off), .dead_cnt(dead_cnt),
        .drv_a(drv_a), .drv_b(drv_b), .sweeping(sweeping)
    );

    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (drv_a && drv_b) overlap <= overlap + 1;
    end

    task automatic check(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic count_edges(input int n, output int cnt);
        logic prev;
        cnt = 0;
        @(negedge clk);
        prev = drv_a;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (drv_a && !prev) cnt++;
            prev = drv_a;
        end
    endtask

    // both-low samples between one phase falling and the other rising
    task automatic measure_gap(input bit a_first, output int gap);
        gap = 0;
        @(negedge clk);
        while (!(a_first ? drv_a : drv_b)) @(negedge clk);
        while ((a_first ? drv_a : drv_b)) @(negedge clk);
        while (!(a_first ? drv_b : drv_a)) begin
            gap++;
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        wait (cycles > 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        int cnt, exp, gap, ceilv;
        wait_cyc(3);
        // R1: reset state
        check("R1 reset drv_a", drv_a, 0, 0);
        check("R1 reset drv_b", drv_b, 0, 0);
        check("R1 reset sweeping", sweeping, 0, 0);
        rst_n = 1'b1;
        wait_cyc(2);

        // R2 / R8: strapped operation over several tuning words
        dead_cnt = 4'd2;
        enable = 1'b1;
        foreach (tune_word[i]) begin end
        for (int k = 0; k < 5; k++) begin
            int tw;
            tw = (k == 0) ? 1024 : (k == 1) ? 2048 : (k == 2) ? 3000 : (k == 3) ? 4096 : 8192;
            tune_word = ACC_W'(tw);
            wait_cyc(40);
            count_edges(WIN, cnt);
            exp = (WIN * tw) / 65536;
            check("R2 edge rate", cnt, exp - 1, exp + 1);
            check("R8 strapped no sweep", sweeping, 0, 0);
        end

        // R4: dead time, both directions
        tune_word = 16'd4096;
        for (int k = 0; k < 3; k++) begin
            int d;
            d = (k == 0) ? 0 : (k == 1) ? 2 : 5;
            dead_cnt = DT_W'(d);
            wait_cyc(40);
            measure_gap(1'b1, gap);
            check("R4 gap a->b", gap, d + 1, d + 1);
            measure_gap(1'b0, gap);
            check("R4 gap b->a", gap, d + 1, d + 1);
        end

        // R1: disable forces everything low
        enable = 1'b0;
        wait_cyc(2);
        check("R1 off drv_a", drv_a, 0, 0);
        check("R1 off drv_b", drv_b, 0, 0);

        // R5: sweep onset after one interval
        dead_cnt = 4'd2;
        sweep_off = 1'b0;
        strike_seen = 1'b0;
        enable = 1'b1;
        wait_cyc(IVL - 2);
        check("R5 no early sweep", sweeping, 0, 0);
        wait_cyc(3);
        check("R5 sweep started", sweeping, 1, 1);

        // R6: settled at ceiling
        wait_cyc(400);
        ceilv = (2 * 4096) / 5;
        count_edges(WIN, cnt);
        exp = (WIN * (4096 + ceilv)) / 65536;
        check("R6 ceiling rate", cnt, exp - 1, exp + 1);

        // R7: gradual glide back after strike
        strike_seen = 1'b1;
        wait_cyc(100);
        check("R7 still gliding", sweeping, 1, 1);
        wait_cyc(300);
        check("R7 glide done", sweeping, 0, 0);
        count_edges(WIN, cnt);
        check("R7 back at base rate", cnt, 511, 513);

        // R9: strike lost, sweep resumes
        strike_seen = 1'b0;
        wait_cyc(20);
        check("R9 sweep resumes", sweeping, 1, 1);

        // R8: strap clears offset
        sweep_off = 1'b1;
        wait_cyc(2);
        check("R8 strap clears", sweeping, 0, 0);

        // R1: disable clears offset; re-enable starts unswept
        sweep_off = 1'b0;
        wait_cyc(100);
        enable = 1'b0;
        wait_cyc(2);
        check("R1 offset cleared", sweeping, 0, 0);
        enable = 1'b1;
        wait_cyc(IVL - 2);
        check("R1 restart unswept", sweeping, 0, 0);

        // R3: non-overlap over whole run
        check("R3 overlap count", overlap, 0, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule